// File: doc/BRIEF.md
# Bipolar Composite Clock Decoder

This block accepts a timing reference that travels on an alternate-mark-inversion line as a 64 kHz clock with 8 kHz frame boundaries. An external slicer turns the line into two digital rails: one goes high for positive marks and the other for negative marks. A fast system clock oversamples both rails. The decoder turns each accepted mark into a toggle of a recovered 64 kHz clock output. It finds the polarity repeats that are inserted on purpose at every eighth mark, and emits a single-cycle frame strobe at each correctly spaced repeat once it has locked to that spacing.

The decoder also checks the mark stream against its nominal form. The departures it detects are a misplaced polarity repeat, a missing repeat, a mark seen on both rails in the same sample, and a silent line. Each departure is weighted into a leaky bucket. The bucket drains by one at every correctly spaced frame marker. A quality alarm with programmable hysteresis tells a downstream reference selector that this input should be disqualified. An input whose rails are both held low is reported as having no activity, and is never reported as a clock.

Top module: `amiCompositeClkDecoder`

## Requirements
- R1: Each rail passes through a two-stage synchronizer, and a mark is accepted on the rising edge of the synchronized rail when only that rail rises in that sample. The recovered clock `clk64` toggles once per accepted mark, on the third rising clock edge after the rail input goes high.
- R2: A polarity repeat is an accepted mark with the same polarity as the previous accepted mark (positive means `railPos`). It is correctly spaced when exactly seven non-repeat marks lie between it and the previous repeat, so that it is the eighth mark.
- R3: After reset or loss of activity, `frameLocked` rises at the second consecutive correctly spaced repeat that follows a first reference repeat. `frameStb` is a one-cycle pulse issued only for correctly spaced repeats that arrive while the block is already locked.
- R4: A polarity repeat at any other position counts as one departure. It drops `frameLocked`, and that repeat becomes the new spacing reference.
- R5: When a spacing reference exists and the eighth mark after it is not a repeat, that mark counts as one departure, drops `frameLocked`, and restarts the eight-mark count.
- R6: Rising edges on both rails in the same sample count as one departure. Such a sample does not toggle `clk64`, and it changes neither the remembered polarity, the mark count nor the lock.
- R7: When no rail edge arrives for GAP_LIMIT system clocks after activity, `noActivity` asserts, one departure is counted, lock and reference are lost, and the next mark is treated as the first. `noActivity` is high from reset until the first rail edge, and an idle line from reset counts no departure.
- R8: The bucket rises by BUCKET_INC per departure, saturating at its maximum. It falls by one on each correctly spaced repeat, locked or not, and never goes below zero.
- R9: `qualAlarm` sets when the bucket is strictly above `thrHigh` and clears when it is strictly below `thrLow`. Between the two thresholds it holds its value.
- R10: `departStb` is high for exactly one cycle per departure, in the same cycle in which the outputs that respond to that mark change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| railPos | input | 1 | Slicer output for positive marks |
| railNeg | input | 1 | Slicer output for negative marks |
| thrHigh | input | BUCKET_W | Bucket level above which the alarm sets |
| thrLow | input | BUCKET_W | Bucket level below which the alarm clears |
| clk64 | output | 1 | Recovered clock, toggles per accepted mark |
| frameStb | output | 1 | One-cycle 8 kHz frame boundary strobe |
| departStb | output | 1 | One-cycle pulse per detected departure |
| frameLocked | output | 1 | Frame alignment achieved |
| qualAlarm | output | 1 | Reference quality alarm with hysteresis |
| noActivity | output | 1 | No rail edges seen recently or since reset |

## Verification
A corrupted mark count or remembered polarity shows up within one eight-mark frame. It appears as a `departStb` pulse on a clean stream, or as a missing `frameStb` once the block is locked. A wrong alignment state shows up as `frameLocked` rising one frame early or late relative to the reference repeat. A bucket off by even one unit moves the cycle in which `qualAlarm` falls by a whole frame during a drain of many frames. The bench probes both thresholds at their exact boundary values for this reason.

// File: rtl/amiDecPkg.sv
package amiDecPkg;

  // Rail edge events reported by the datapath
  typedef struct packed {
    logic risePos;
    logic riseNeg;
    logic timeout;
  } railEvents_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic pulse;     // single-rail mark accepted
    logic depart;    // one departure from nominal pattern
    logic frame;     // correctly spaced repeat (bucket leak)
    logic frameOut;  // frame strobe to be issued (locked)
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    A_SEARCH,  // no spacing reference
    A_REF,     // reference repeat seen
    A_ONE,     // one correctly spaced repeat seen
    A_LOCK     // aligned
  } alignState_t;

endpackage

// File: rtl/amiDecDatapath.sv
module amiDecDatapath
  import amiDecPkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int GAP_LIMIT  = 2930,
  parameter int BUCKET_W   = 8,
  parameter int BUCKET_INC = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                railPos,
  input  logic                railNeg,
  input  logic [BUCKET_W-1:0] thrHigh,
  input  logic [BUCKET_W-1:0] thrLow,
  input  ctlStrobes_t         cmd,
  output railEvents_t         evt,
  output logic                clk64,
  output logic                frameStb,
  output logic                departStb,
  output logic                qualAlarm,
  output logic                noActivity
);

  localparam int GAP_W      = $clog2(GAP_LIMIT + 1);
  localparam int BUCKET_MAX = (1 << BUCKET_W) - 1;

  // Synchronizer and rising-edge detect, one per rail
  logic [1:0] railIn;
  logic [1:0] riseVec;
  assign railIn = {railNeg, railPos};

  for (genvar r = 0; r < 2; r++) begin : gRail
    logic [SYNC_DEPTH-1:0] pipe;
    logic                  last;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pipe <= '0;
        last <= 1'b0;
      end else begin
        pipe <= {pipe[SYNC_DEPTH-2:0], railIn[r]};
        last <= pipe[SYNC_DEPTH-1];
      end
    end
    assign riseVec[r] = pipe[SYNC_DEPTH-1] & ~last;
  end

  // Activity timer
  logic [GAP_W-1:0] gapCnt;
  logic             anyRise;
  logic             timeoutNow;

  assign anyRise    = |riseVec;
  assign timeoutNow = !noActivity && !anyRise && (gapCnt == GAP_W'(GAP_LIMIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt     <= '0;
      noActivity <= 1'b1;
    end else if (anyRise) begin
      gapCnt     <= '0;
      noActivity <= 1'b0;
    end else if (timeoutNow) begin
      gapCnt     <= '0;
      noActivity <= 1'b1;
    end else if (!noActivity) begin
      gapCnt     <= gapCnt + 1'b1;
    end
  end

  assign evt = '{risePos: riseVec[0], riseNeg: riseVec[1], timeout: timeoutNow};

  // Leaky bucket and hysteresis alarm
  logic [BUCKET_W-1:0] bucket;
  logic [BUCKET_W:0]   bucketSum;
  assign bucketSum = {1'b0, bucket} + (BUCKET_W + 1)'(BUCKET_INC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bucket <= '0;
    end else if (cmd.depart) begin
      bucket <= (bucketSum > (BUCKET_W + 1)'(BUCKET_MAX)) ? '1 : bucketSum[BUCKET_W-1:0];
    end else if (cmd.frame && bucket != '0) begin
      bucket <= bucket - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualAlarm <= 1'b0;
    end else if (bucket > thrHigh) begin
      qualAlarm <= 1'b1;
    end else if (bucket < thrLow) begin
      qualAlarm <= 1'b0;
    end
  end

  // Registered outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clk64     <= 1'b0;
      frameStb  <= 1'b0;
      departStb <= 1'b0;
    end else begin
      clk64     <= clk64 ^ cmd.pulse;
      frameStb  <= cmd.frameOut;
      departStb <= cmd.depart;
    end
  end

  AST_TOGGLE_NEEDS_ACTIVITY: assert property (@(posedge clk) disable iff (!rstN)
    (clk64 != $past(clk64)) |-> !noActivity); // R1
  AST_BUCKET_UP_ON_DEPART: assert property (@(posedge clk) disable iff (!rstN)
    (bucket > $past(bucket)) |-> $past(cmd.depart)); // R8
  AST_BUCKET_DOWN_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (bucket < $past(bucket)) |-> (bucket == $past(bucket) - 1'b1)); // R8
  AST_ALARM_SET_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qualAlarm) |-> ($past(bucket) > $past(thrHigh))); // R9
  AST_ALARM_CLEAR_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(qualAlarm) |-> ($past(bucket) < $past(thrLow))); // R9
  AST_TIMEOUT_DEPARTS: assert property (@(posedge clk) disable iff (!rstN)
    timeoutNow |=> (departStb && noActivity)); // R7

endmodule

// File: rtl/amiDecControl.sv
module amiDecControl
  import amiDecPkg::*;
#(
  parameter int FRAME_LEN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  railEvents_t evt,
  output ctlStrobes_t cmd,
  output logic        frameLocked
);

  localparam int CNT_W = $clog2(FRAME_LEN);

  alignState_t      alignState;
  logic             havePrev;
  logic             lastPol;
  logic [CNT_W-1:0] sinceViol;

  logic single, dual, pol, isViol, haveRef, spacingOk;
  logic goodViol, badViol, missing;

  assign single    = evt.risePos ^ evt.riseNeg;
  assign dual      = evt.risePos & evt.riseNeg;
  assign pol       = evt.risePos;
  assign isViol    = single && havePrev && (pol == lastPol);
  assign haveRef   = (alignState != A_SEARCH);
  assign spacingOk = (sinceViol == CNT_W'(FRAME_LEN - 1));
  assign goodViol  = isViol && haveRef && spacingOk;
  assign badViol   = isViol && haveRef && !spacingOk;
  assign missing   = single && !isViol && haveRef && spacingOk;

  assign cmd = '{pulse:    single,
                 depart:   dual | badViol | missing | evt.timeout,
                 frame:    goodViol,
                 frameOut: goodViol && (alignState == A_LOCK)};

  assign frameLocked = (alignState == A_LOCK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alignState <= A_SEARCH;
      havePrev   <= 1'b0;
      lastPol    <= 1'b0;
      sinceViol  <= '0;
    end else if (evt.timeout) begin
      alignState <= A_SEARCH;
      havePrev   <= 1'b0;
      sinceViol  <= '0;
    end else if (single) begin
      havePrev <= 1'b1;
      lastPol  <= pol;
      if (isViol || spacingOk) sinceViol <= '0;
      else                     sinceViol <= sinceViol + 1'b1;
      if (isViol) begin
        unique case (alignState)
          A_SEARCH: alignState <= A_REF;
          A_REF:    alignState <= goodViol ? A_ONE : A_REF;
          A_ONE:    alignState <= goodViol ? A_LOCK : A_REF;
          A_LOCK:   alignState <= goodViol ? A_LOCK : A_REF;
          default:  alignState <= A_SEARCH;
        endcase
      end else if (missing) begin
        alignState <= A_REF;
      end
    end
  end

  AST_LOCK_FROM_ONE_GOOD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameLocked) |-> ($past(alignState) == A_ONE)); // R3
  AST_TIMEOUT_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    evt.timeout |=> (alignState == A_SEARCH && !frameLocked)); // R7
  AST_DUAL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    dual |=> $stable(sinceViol)); // R6

endmodule

// File: rtl/amiCompositeClkDecoder.sv
module amiCompositeClkDecoder
  import amiDecPkg::*;
#(
  parameter int SYNC_DEPTH = 2,
  parameter int FRAME_LEN  = 8,
  parameter int GAP_LIMIT  = 2930,
  parameter int BUCKET_W   = 8,
  parameter int BUCKET_INC = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                railPos,
  input  logic                railNeg,
  input  logic [BUCKET_W-1:0] thrHigh,
  input  logic [BUCKET_W-1:0] thrLow,
  output logic                clk64,
  output logic                frameStb,
  output logic                departStb,
  output logic                frameLocked,
  output logic                qualAlarm,
  output logic                noActivity
);

  railEvents_t evt;
  ctlStrobes_t cmd;

  amiDecDatapath #(
    .SYNC_DEPTH(SYNC_DEPTH),
    .GAP_LIMIT (GAP_LIMIT),
    .BUCKET_W  (BUCKET_W),
    .BUCKET_INC(BUCKET_INC)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .railPos   (railPos),
    .railNeg   (railNeg),
    .thrHigh   (thrHigh),
    .thrLow    (thrLow),
    .cmd       (cmd),
    .evt       (evt),
    .clk64     (clk64),
    .frameStb  (frameStb),
    .departStb (departStb),
    .qualAlarm (qualAlarm),
    .noActivity(noActivity)
  );

  amiDecControl #(
    .FRAME_LEN(FRAME_LEN)
  ) uControl (
    .clk        (clk),
    .rstN       (rstN),
    .evt        (evt),
    .cmd        (cmd),
    .frameLocked(frameLocked)
  );

  AST_FRAME_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    frameStb |-> frameLocked); // R3
  AST_FRAME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    frameStb |=> !frameStb); // R3

endmodule

// File: tb/sim_amiCompositeClkDecoder.sv
module sim_amiCompositeClkDecoder;

  localparam int GAP  = 40;
  localparam int BW   = 6;
  localparam int INC  = 4;
  localparam int BMAX = 63;
  localparam logic [BW-1:0] HI = 6'd10;
  localparam logic [BW-1:0] LO = 6'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic railPos = 1'b0;
  logic railNeg = 1'b0;
  logic clk64, frameStb, departStb, frameLocked, qualAlarm, noActivity;

  always #4 clk = ~clk;

  amiCompositeClkDecoder #(
    .SYNC_DEPTH(2), .FRAME_LEN(8), .GAP_LIMIT(GAP), .BUCKET_W(BW), .BUCKET_INC(INC)
  ) u0 (
    .clk(clk), .rstN(rstN), .railPos(railPos), .railNeg(railNeg),
    .thrHigh(HI), .thrLow(LO),
    .clk64(clk64), .frameStb(frameStb), .departStb(departStb),
    .frameLocked(frameLocked), .qualAlarm(qualAlarm), .noActivity(noActivity)
  );

  int checks = 0, fails = 0;
  int frameCnt = 0, departCnt = 0, toggleCnt = 0, wideFrame = 0, wideDepart = 0;
  int expDepart = 0, expFrame = 0, expToggle = 0, expBucket = 0;
  logic expAlarm = 1'b0;
  logic monOn = 1'b0;
  logic prevClk = 1'b0, prevFrame = 1'b0, prevDepart = 1'b0;
  logic lastPol = 1'b0;

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (monOn) begin
      if (clk64 !== prevClk) toggleCnt++;
      if (frameStb) frameCnt++;
      if (departStb) departCnt++;
      if (frameStb && prevFrame) wideFrame++;
      if (departStb && prevDepart) wideDepart++;
    end
    prevClk = clk64;
    prevFrame = frameStb;
    prevDepart = departStb;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void updAlarm();
    if (expBucket > int'(HI)) expAlarm = 1'b1;
    else if (expBucket < int'(LO)) expAlarm = 1'b0;
  endfunction

  function automatic void noteDepart();
    expDepart++;
    expBucket = (expBucket + INC > BMAX) ? BMAX : expBucket + INC;
    updAlarm();
  endfunction

  function automatic void noteLeak();
    if (expBucket > 0) expBucket--;
    updAlarm();
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendPulse(logic pol);
    @(negedge clk);
    railPos = pol;
    railNeg = ~pol;
    repeat (3) @(negedge clk);
    railPos = 1'b0;
    railNeg = 1'b0;
    repeat (12) @(negedge clk);
    lastPol = pol;
    expToggle++;
  endtask

  task automatic sendDual();
    @(negedge clk);
    railPos = 1'b1;
    railNeg = 1'b1;
    repeat (3) @(negedge clk);
    railPos = 1'b0;
    railNeg = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  // v+1 marks; the last repeats the previous polarity
  task automatic sendGroup(int v);
    for (int k = 0; k <= v; k++) sendPulse((k == v) ? lastPol : ~lastPol);
  endtask

  task automatic sendAlt(int n);
    for (int k = 0; k < n; k++) sendPulse(~lastPol);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R7", "noActivity after reset", int'(noActivity), 1);
    chk("R3", "frameLocked after reset", int'(frameLocked), 0);
    chk("R9", "qualAlarm after reset", int'(qualAlarm), 0);
    chk("R1", "clk64 after reset", int'(clk64), 0);
    prevClk = clk64;
    monOn = 1'b1;

    // R7: idle line from reset counts nothing
    idle(3 * GAP);
    chk("R7", "idle from reset noActivity", int'(noActivity), 1);
    chk("R7", "idle from reset departures", departCnt, 0);

    // R1: latency of the first mark
    railPos = 1'b1;
    idle(2);
    chk("R1", "clk64 before third edge", int'(clk64), 0);
    idle(1);
    chk("R1", "clk64 at third edge", int'(clk64), 1);
    chk("R7", "noActivity cleared by mark", int'(noActivity), 0);
    idle(1);
    railPos = 1'b0;
    lastPol = 1'b1;
    expToggle++;

    // R7: silence after activity
    idle(GAP + 10);
    noteDepart();
    chk("R7", "timeout noActivity", int'(noActivity), 1);
    chk("R7", "timeout departure", departCnt, expDepart);

    // R2/R3: nominal stream, reference then two good repeats
    sendGroup(7);
    sendGroup(7);
    noteLeak();
    chk("R3", "not locked after one good repeat", int'(frameLocked), 0);
    sendGroup(7);
    noteLeak();
    chk("R3", "locked after second good repeat", int'(frameLocked), 1);
    chk("R3", "no strobe while acquiring", frameCnt, 0);
    sendGroup(7);
    noteLeak();
    sendGroup(7);
    noteLeak();
    expFrame += 2;
    chk("R2", "frame strobes nominal", frameCnt, expFrame);
    chk("R2", "no departures nominal", departCnt, expDepart);
    chk("R1", "toggles nominal", toggleCnt, expToggle);

    // R4: misplaced repeat
    sendGroup(3);
    noteDepart();
    chk("R4", "misplaced departure", departCnt, expDepart);
    chk("R4", "misplaced drops lock", int'(frameLocked), 0);
    for (int g = 0; g < 3; g++) begin
      sendGroup(7);
      noteLeak();
    end
    expFrame++;
    chk("R4", "relock from new reference", frameCnt, expFrame);

    // R5: missing repeat
    sendAlt(8);
    noteDepart();
    chk("R5", "missing departure", departCnt, expDepart);
    chk("R5", "missing drops lock", int'(frameLocked), 0);
    sendGroup(7);
    noteLeak();
    sendGroup(7);
    noteLeak();
    chk("R5", "relock after missing", int'(frameLocked), 1);
    chk("R5", "no strobe during relock", frameCnt, expFrame);

    // R6: mark on both rails
    sendDual();
    noteDepart();
    chk("R6", "dual departure", departCnt, expDepart);
    chk("R6", "dual does not toggle", toggleCnt, expToggle);
    chk("R6", "dual keeps lock", int'(frameLocked), 1);
    sendGroup(7);
    noteLeak();
    expFrame++;
    chk("R6", "count unchanged by dual", frameCnt, expFrame);

    // R8/R9: bucket and alarm thresholds
    sendDual();
    noteDepart();
    chk("R9", "alarm at bucket equal high", int'(qualAlarm), int'(expAlarm));
    sendDual();
    noteDepart();
    chk("R9", "alarm above high", int'(qualAlarm), int'(expAlarm));
    for (int g = 0; g < 11; g++) begin
      sendGroup(7);
      noteLeak();
      expFrame++;
    end
    chk("R8", "alarm held at bucket equal low", int'(qualAlarm), int'(expAlarm));
    sendGroup(7);
    noteLeak();
    expFrame++;
    chk("R8", "alarm cleared below low", int'(qualAlarm), int'(expAlarm));
    chk("R3", "frame strobes after drain", frameCnt, expFrame);

    // R7: loss of activity while locked
    idle(GAP + 10);
    noteDepart();
    chk("R7", "timeout while locked noActivity", int'(noActivity), 1);
    chk("R7", "timeout drops lock", int'(frameLocked), 0);
    chk("R10", "total departures", departCnt, expDepart);
    chk("R10", "departStb width", wideDepart, 0);
    chk("R3", "frameStb width", wideFrame, 0);
    chk("R1", "total toggles", toggleCnt, expToggle);

    summary();
    $finish;
  end

endmodule